// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes. A single-cycle tick, normally a once-per-second pulse from a prescaler outside the block, advances the seconds. Any carry runs through minutes, hours, day of week, date, month and year, and into a century flag, all within the cycle that takes the tick. Month lengths come from the month number. February's length depends on whether the BCD year is a multiple of four.

A host updates the counter one field at a time through a synchronous write port. A write takes effect at the next clock edge. All fields are presented in parallel as bytes, so a register interface can read them out.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00. Day of week, date and month read 0x01. The century flag reads 0.
- R2: A tick in a cycle with no write advances the seconds by one in BCD. 0x59 wraps to 0x00 and carries into minutes, and minutes wrap from 0x59 to 0x00 and carry into hours. All carries settle at the clock edge that takes the tick.
- R3: Hours count from 0x00 to 0x23. A carry out of 0x23 returns hours to 0x00 and advances the day of week and the date.
- R4: Day of week counts from 0x01 to 0x07. It returns to 0x01 after 0x07 and advances only when the date advances.
- R5: The date returns to 0x01 and the month advances after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12.
- R6: In February the date rolls over after 0x29 when the year value is a multiple of four, 0x00 included. In all other years it rolls over after 0x28.
- R7: Month 0x12 returns to 0x01 and advances the year. Year 0x99 returns to 0x00 and toggles the century flag, which is bit 7 of `mon_cen`. Bits 6:0 of `mon_cen` hold the month.
- R8: When `wr_en` is high, `wr_data` is stored at the next edge in the field chosen by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month with the century flag, 6 year. For select 5, bit 7 is the century flag and bits 6:0 are the month.
- R9: A tick in the same cycle as a write is dropped entirely. Only the written field changes.
- R10: With neither tick nor write, every output holds its value.
- R11: A date that was written above the current month's last date is handled as the last date. The next day carry sets it to 0x01 and advances the month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle advance pulse |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Packed BCD write value |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hours, BCD, 24-hour |
| dow | output | 8 | Day of week, BCD 1 to 7 |
| date | output | 8 | Day of month, BCD |
| mon_cen | output | 8 | Century flag in bit 7, BCD month in bits 6:0 |
| year | output | 8 | Year, BCD |

## Verification
Year-end rollover, leap-day handling and century toggling each need years of ticks to reach from reset, so that path is not driven by ticking alone. The stimulus first uses the write port to place the counter one second before each boundary: 23:59:59 on the last day of a 30-day month, a 31-day month, February in leap and common years, and 31 December 99. A single tick then makes the entire carry chain ripple in one cycle. A date written past the end of February covers the out-of-range case the same way.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DOW  = 3'd3,
    F_DATE = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } field_sel_e;

  // increment a two-digit packed BCD value
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // tens*10+ones divisible by 4: even tens need ones 0/4/8, odd tens need 2/6
  function automatic logic bcd_leap(input logic [BYTE_W-1:0] y);
    if (y[4] == 1'b0) bcd_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else              bcd_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [BYTE_W-1:0] bcd_last_date(input logic [BYTE_W-1:0] m,
                                                        input logic leap);
    case (m)
      8'h02:                      bcd_last_date = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: bcd_last_date = 8'h30;
      default:                    bcd_last_date = 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcdcal_month_len.sv
module bcdcal_month_len
  import bcdcal_pkg::*;
(
  input  logic [BYTE_W-1:0] month,
  input  logic [BYTE_W-1:0] year,
  output logic              leap,
  output logic [BYTE_W-1:0] last_date
);
  always_comb begin
    leap      = bcd_leap(year);
    last_date = bcd_last_date(month, leap);
  end
endmodule

// File: rtl/bcdcal_field.sv
module bcdcal_field
  import bcdcal_pkg::*;
#(
  parameter int          W       = 8,
  parameter logic [W-1:0] LO     = '0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hi,
  input  logic         step,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  logic [BYTE_W-1:0] q_ext;
  logic [BYTE_W-1:0] q_inc;
  logic              at_top;

  always_comb begin
    q_ext  = BYTE_W'(q);
    q_inc  = bcd_inc(q_ext);
    at_top = (q >= hi);
    wrap   = step && at_top;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST_VAL;
    else if (ld)     q <= ld_val;
    else if (step)   q <= at_top ? LO : W'(q_inc);
  end

  assert_field_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && q >= hi) |=> (q == LO));
  assert_field_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(ld_val)));
endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
  import bcdcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] sec,
  output logic [BYTE_W-1:0] min,
  output logic [BYTE_W-1:0] hour,
  output logic [BYTE_W-1:0] dow,
  output logic [BYTE_W-1:0] date,
  output logic [BYTE_W-1:0] mon_cen,
  output logic [BYTE_W-1:0] year
);
  localparam int MON_W = BYTE_W - 1;

  logic advance;
  logic ld_sec, ld_min, ld_hour, ld_dow, ld_date, ld_mon, ld_year;
  logic sec_wrap, min_wrap, hour_wrap, dow_wrap, date_wrap, mon_wrap, year_wrap;
  logic [MON_W-1:0]  mon_q;
  logic [BYTE_W-1:0] last_date;
  logic              leap_yr;
  logic              century;

  always_comb begin
    advance = tick_1hz && !wr_en;
    ld_sec  = wr_en && (wr_sel == F_SEC);
    ld_min  = wr_en && (wr_sel == F_MIN);
    ld_hour = wr_en && (wr_sel == F_HOUR);
    ld_dow  = wr_en && (wr_sel == F_DOW);
    ld_date = wr_en && (wr_sel == F_DATE);
    ld_mon  = wr_en && (wr_sel == F_MON);
    ld_year = wr_en && (wr_sel == F_YEAR);
  end

  bcdcal_month_len u_len (
    .month(BYTE_W'(mon_q)), .year(year), .leap(leap_yr), .last_date(last_date)
  );

  bcdcal_field #(.W(BYTE_W), .LO(8'h00), .RST_VAL(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .hi(8'h59), .step(advance), .ld(ld_sec),
    .ld_val(wr_data), .q(sec), .wrap(sec_wrap));

  bcdcal_field #(.W(BYTE_W), .LO(8'h00), .RST_VAL(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .hi(8'h59), .step(sec_wrap), .ld(ld_min),
    .ld_val(wr_data), .q(min), .wrap(min_wrap));

  bcdcal_field #(.W(BYTE_W), .LO(8'h00), .RST_VAL(8'h00)) u_hour (
    .clk(clk), .rst_n(rst_n), .hi(8'h23), .step(min_wrap), .ld(ld_hour),
    .ld_val(wr_data), .q(hour), .wrap(hour_wrap));

  bcdcal_field #(.W(BYTE_W), .LO(8'h01), .RST_VAL(8'h01)) u_dow (
    .clk(clk), .rst_n(rst_n), .hi(8'h07), .step(hour_wrap), .ld(ld_dow),
    .ld_val(wr_data), .q(dow), .wrap(dow_wrap));

  bcdcal_field #(.W(BYTE_W), .LO(8'h01), .RST_VAL(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .hi(last_date), .step(hour_wrap), .ld(ld_date),
    .ld_val(wr_data), .q(date), .wrap(date_wrap));

  bcdcal_field #(.W(MON_W), .LO(7'h01), .RST_VAL(7'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .hi(7'h12), .step(date_wrap), .ld(ld_mon),
    .ld_val(wr_data[MON_W-1:0]), .q(mon_q), .wrap(mon_wrap));

  bcdcal_field #(.W(BYTE_W), .LO(8'h00), .RST_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .hi(8'h99), .step(mon_wrap), .ld(ld_year),
    .ld_val(wr_data), .q(year), .wrap(year_wrap));

  always_ff @(posedge clk) begin
    if (!rst_n)         century <= 1'b0;
    else if (ld_mon)    century <= wr_data[BYTE_W-1];
    else if (year_wrap) century <= ~century;
  end

  assign mon_cen = {century, mon_q};

  // century only moves on a month write or on the 99 -> 00 year rollover
  assert_century_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(century) |->
      ($past(ld_mon) || ($past(year) == 8'h99 && year == 8'h00)));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1hz && !wr_en) |=>
      ($stable(sec) && $stable(min) && $stable(hour) && $stable(dow) &&
       $stable(date) && $stable(mon_cen) && $stable(year)));
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && wr_en && wr_sel != F_SEC) |=> $stable(sec));
  assert_dow_with_date_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dow) && !$past(wr_en)) |-> !$stable(date));
  assert_hour_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(min_wrap) && $past(hour) == 8'h23) |-> (hour == 8'h00));
endmodule

// File: tb/test_bcd_clock_calendar.sv
module test_bcd_clock_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec, min, hour, dow, date, mon_cen, year;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model in plain binary
  int s, m, h, dw, d, mo, y, c;

  logic [55:0] exp_q[$];
  string       req_q[$];

  always #2 clk = ~clk;

  bcd_clock_calendar i_bcd_clock_calendar (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .sec(sec), .min(min), .hour(hour),
    .dow(dow), .date(date), .mon_cen(mon_cen), .year(year));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_of(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] model_bytes();
    return {to_bcd(s), to_bcd(m), to_bcd(h), to_bcd(dw), to_bcd(d),
            (c != 0) ? 8'h80 | to_bcd(mo) : to_bcd(mo), to_bcd(y)};
  endfunction

  task automatic model_tick();
    s++;
    if (s > 59) begin
      s = 0; m++;
      if (m > 59) begin
        m = 0; h++;
        if (h > 23) begin
          h = 0;
          dw = (dw == 7) ? 1 : dw + 1;
          d++;
          if (d > days_of(mo, y)) begin
            d = 1; mo++;
            if (mo > 12) begin
              mo = 1; y++;
              if (y > 99) begin y = 0; c = 1 - c; end
            end
          end
        end
      end
    end
  endtask

  function automatic void compare(input logic [55:0] exp, input string req);
    logic [55:0] act;
    act = {sec, min, hour, dow, date, mon_cen, year};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  // driver: one operation per call, expected result pushed before the edge
  task automatic apply(input bit tk, input bit we, input int sel,
                       input int val, input int cen, input string req);
    @(negedge clk);
    tick_1hz = tk;
    wr_en    = we;
    wr_sel   = 3'(sel);
    wr_data  = to_bcd(val);
    if (we) begin
      case (sel)
        0: s = val;
        1: m = val;
        2: h = val;
        3: dw = val;
        4: d = val;
        5: begin mo = val; c = cen; wr_data = (cen != 0) ? 8'h80 | to_bcd(val) : to_bcd(val); end
        default: y = val;
      endcase
    end else if (tk) begin
      model_tick();
    end
    exp_q.push_back(model_bytes());
    req_q.push_back(req);
    @(negedge clk);
    tick_1hz = 1'b0;
    wr_en    = 1'b0;
  endtask

  task automatic tick(input string req);
    apply(1'b1, 1'b0, 0, 0, 0, req);
  endtask

  task automatic set_time(input int yy, input int mm, input int cen, input int dd,
                          input int wd, input int hh, input int mi, input int ss);
    apply(0, 1, 6, yy, 0, "R8");
    apply(0, 1, 5, mm, cen, "R8");
    apply(0, 1, 4, dd, 0, "R8");
    apply(0, 1, 3, wd, 0, "R8");
    apply(0, 1, 2, hh, 0, "R8");
    apply(0, 1, 1, mi, 0, "R8");
    apply(0, 1, 0, ss, 0, "R8");
  endtask

  // monitor: compare one item per clock after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), req_q.pop_front());
    end
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    s = 0; m = 0; h = 0; dw = 1; d = 1; mo = 1; y = 0; c = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(model_bytes(), "R1 reset");

    // R2 plain counting
    for (int i = 0; i < 5; i++) tick("R2 count");
    // R10 idle: the monitor compares after each apply's edge; an idle op
    apply(0, 0, 0, 0, 0, "R10 idle");
    repeat (3) @(negedge clk);
    compare(model_bytes(), "R10 idle hold");

    // R2 seconds and minute carry
    set_time(24, 3, 0, 10, 2, 5, 58, 58);
    tick("R2 sec");
    tick("R2 min carry");
    tick("R2 sec after carry");

    // R3/R4 hour wrap, dow 7 -> 1
    set_time(24, 3, 0, 10, 7, 23, 59, 59);
    tick("R3 R4 day change");

    // R5 30-day and 31-day months
    set_time(23, 4, 0, 30, 3, 23, 59, 59);
    tick("R5 april end");
    set_time(23, 1, 0, 31, 3, 23, 59, 59);
    tick("R5 january end");
    set_time(23, 11, 0, 30, 3, 23, 59, 59);
    tick("R5 november end");

    // R6 leap rule
    set_time(24, 2, 0, 28, 1, 23, 59, 59);
    tick("R6 leap feb 29");
    apply(0, 1, 2, 23, 0, "R8");
    apply(0, 1, 1, 59, 0, "R8");
    apply(0, 1, 0, 59, 0, "R8");
    tick("R6 leap to march");
    set_time(23, 2, 0, 28, 1, 23, 59, 59);
    tick("R6 common to march");
    set_time(0, 2, 1, 28, 1, 23, 59, 59);
    tick("R6 year 00 leap");
    set_time(98, 2, 0, 28, 1, 23, 59, 59);
    tick("R6 year 98 common");

    // R7 year and century
    set_time(99, 12, 0, 31, 7, 23, 59, 59);
    tick("R7 century set");
    set_time(99, 12, 1, 31, 4, 23, 59, 59);
    tick("R7 century clear");
    set_time(41, 12, 0, 31, 4, 23, 59, 59);
    tick("R7 year advance");

    // R9 write with tick
    set_time(30, 6, 0, 15, 3, 12, 30, 59);
    apply(1, 1, 1, 45, 0, "R9 write wins");
    apply(1, 1, 0, 12, 0, "R9 write sec wins");

    // R11 out-of-range date
    set_time(23, 2, 0, 31, 5, 23, 59, 59);
    tick("R11 feb 31");
    set_time(23, 9, 0, 31, 5, 23, 59, 59);
    tick("R11 sep 31");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule